// File: doc/BRIEF.md
# Sub-Word Lane Multiply-Accumulate with Right Shift

This block is a two-stage arithmetic datapath for packed video-style data. It takes two 32-bit words, pulls one narrow lane out of each (a byte picked by index, or the lower or upper 16-bit half), and widens each lane to 32 bits. It multiplies the two lanes, adds a full 32-bit third operand, and can then shift the sum right by 7 or by 15. The second factor can come from a 16-bit immediate field instead of a register lane. Each source carries its own sign flag. The whole operation counts as signed when either flag is set.

A transfer is offered with `in_valid`. The result leaves two clock cycles later, together with `out_valid`, and a new transfer can start on every cycle. The full-word lane type and the reserved lane type are not supported. When either is requested, the transfer still completes, but it carries a zero result and a raised `err` flag.

Top module: `vlane_muladd`

## Requirements
- R1: With byte mode set (`*_byte_mode`=1), the operand is the 8-bit lane at bits [8*idx+7 : 8*idx], where idx is `*_byte_idx` (0 to 3).
- R2: With byte mode clear, a half selector of 0 takes bits [15:0] and a half selector of 1 takes bits [31:16].
- R3: An extracted lane is sign-extended to 32 bits when its own sign flag (`a_signed` or `b_signed`) is 1, and zero-extended when it is 0.
- R4: With `b_from_imm`=1, B is `b_imm`, sign-extended when `b_signed`=1 and zero-extended otherwise. `b_word` and all B lane controls have no effect on `result` or `err`.
- R5: The value before the shift is the low 32 bits of A*B + `c_word`.
- R6: `shift_sel` 1 shifts right by 7, 2 shifts right by 15, and 0 or 3 applies no shift. The shift is arithmetic when `a_signed` or `b_signed` is 1, and logical otherwise.
- R7: A source that is used in halfword mode with half selector 2 (full word) or 3 (reserved) makes the transfer complete with `result`=0 and `err`=1. Otherwise `err`=0.
- R8: `out_valid` rises exactly two cycles after `in_valid` is sampled high. Back-to-back transfers come out one per cycle, in order.
- R9: Reset clears `out_valid`, `result` and `err`. While `out_valid` is 0, `result` and `err` hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Transfer offered this cycle |
| a_word | input | 32 | Register source for A |
| a_byte_mode | input | 1 | 1: byte lane for A, 0: halfword lane |
| a_byte_idx | input | 2 | Byte index for A |
| a_half_sel | input | 2 | A half selector: 0 low, 1 high, 2 full word (error), 3 reserved (error) |
| a_signed | input | 1 | A sign flag |
| b_word | input | 32 | Register source for B |
| b_imm | input | 16 | Immediate source for B |
| b_from_imm | input | 1 | 1: B from immediate, 0: B from register lane |
| b_byte_mode | input | 1 | 1: byte lane for B, 0: halfword lane |
| b_byte_idx | input | 2 | Byte index for B |
| b_half_sel | input | 2 | B half selector, same coding as A |
| b_signed | input | 1 | B sign flag |
| c_word | input | 32 | Addend |
| shift_sel | input | 2 | 0 none, 1 right by 7, 2 right by 15, 3 none |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Shifted multiply-add result |
| err | output | 1 | Unsupported lane type was requested |

## Verification
The hardest case to reach is a negative sum that goes through the shifter. It needs a signed lane holding a negative value, a product that stays negative after the addend, and a shift code other than 0 or 3, all in one transfer. The sweep reaches it by pairing every lane position and half type of A with every B source, crossed with all four sign-flag pairs and all four shift codes. The operand patterns are chosen so that top-bit-set bytes and halves land in each lane. The immediate cases also drive reserved B lane controls and random `b_word` values, which shows at `result` and `err` that those inputs are ignored.

// File: rtl/vlane_pkg.sv
package vlane_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned IMM_W      = 16;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned HALF_W     = 16;
    localparam int unsigned N_BYTES    = WORD_W / BYTE_W;
    localparam int unsigned BYTE_IDX_W = $clog2(N_BYTES);

    typedef enum logic [1:0] {
        HALF_LO   = 2'd0,
        HALF_HI   = 2'd1,
        HALF_FULL = 2'd2,
        HALF_RSVD = 2'd3
    } half_sel_e;

    typedef enum logic [1:0] {
        SHR_NONE  = 2'd0,
        SHR_SMALL = 2'd1,
        SHR_LARGE = 2'd2,
        SHR_RSVD  = 2'd3
    } shift_sel_e;

    typedef struct packed {
        logic                  byte_mode;
        logic [BYTE_IDX_W-1:0] byte_idx;
        half_sel_e             half_sel;
        logic                  is_signed;
    } lane_ctl_t;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic              op_signed;
        shift_sel_e        shift;
        logic [WORD_W-1:0] a_op;
        logic [WORD_W-1:0] b_op;
        logic [WORD_W-1:0] c_op;
    } stage_t;

    function automatic logic [WORD_W-1:0] widen_byte(input logic [BYTE_W-1:0] v,
                                                     input logic s);
        return {{(WORD_W-BYTE_W){s & v[BYTE_W-1]}}, v};
    endfunction

    function automatic logic [WORD_W-1:0] widen_half(input logic [HALF_W-1:0] v,
                                                     input logic s);
        return {{(WORD_W-HALF_W){s & v[HALF_W-1]}}, v};
    endfunction

    function automatic logic [WORD_W-1:0] widen_imm(input logic [IMM_W-1:0] v,
                                                    input logic s);
        return {{(WORD_W-IMM_W){s & v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/vlane_lane_pick.sv
module vlane_lane_pick
    import vlane_pkg::*;
#(
    parameter bit HAS_IMM = 1'b0
) (
    input  logic [WORD_W-1:0] word,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  lane_ctl_t         ctl,
    output logic [WORD_W-1:0] operand,
    output logic              bad
);

    logic [BYTE_W-1:0] lanes [N_BYTES];
    logic [HALF_W-1:0] half_lo;
    logic [HALF_W-1:0] half_hi;

    for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
        assign lanes[g] = word[g*BYTE_W +: BYTE_W];
    end

    assign half_lo = word[HALF_W-1:0];
    assign half_hi = word[WORD_W-1 -: HALF_W];

    logic [WORD_W-1:0] reg_operand;
    logic              reg_bad;

    always_comb begin
        reg_operand = '0;
        reg_bad     = 1'b0;
        if (ctl.byte_mode) begin
            reg_operand = widen_byte(lanes[ctl.byte_idx], ctl.is_signed);
        end else begin
            unique case (ctl.half_sel)
                HALF_LO: reg_operand = widen_half(half_lo, ctl.is_signed);
                HALF_HI: reg_operand = widen_half(half_hi, ctl.is_signed);
                default: reg_bad     = 1'b1;
            endcase
        end
    end

    if (HAS_IMM) begin : g_with_imm
        always_comb begin
            if (use_imm) begin
                operand = widen_imm(imm, ctl.is_signed);
                bad     = 1'b0;
            end else begin
                operand = reg_operand;
                bad     = reg_bad;
            end
        end
    end else begin : g_reg_only
        logic unused_imm;
        assign unused_imm = use_imm ^ (^imm);
        assign operand    = reg_operand;
        assign bad        = reg_bad & ~(unused_imm & 1'b0);
    end

endmodule

// File: rtl/vlane_mac.sv
module vlane_mac
    import vlane_pkg::*;
#(
    parameter int unsigned SHIFT_SMALL = 7,
    parameter int unsigned SHIFT_LARGE = 15
) (
    input  logic [WORD_W-1:0] a_op,
    input  logic [WORD_W-1:0] b_op,
    input  logic [WORD_W-1:0] c_op,
    input  logic              op_signed,
    input  shift_sel_e        shift,
    output logic [WORD_W-1:0] value
);

    logic [WORD_W-1:0]        prod;
    logic [WORD_W-1:0]        sum;
    logic signed [WORD_W-1:0] ssum;
    logic signed [WORD_W-1:0] sar_small;
    logic signed [WORD_W-1:0] sar_large;
    logic [WORD_W-1:0]        shr_small;
    logic [WORD_W-1:0]        shr_large;

    always_comb begin
        prod      = a_op * b_op;
        sum       = prod + c_op;
        ssum      = sum;
        sar_small = ssum >>> SHIFT_SMALL;
        sar_large = ssum >>> SHIFT_LARGE;
        shr_small = sum >> SHIFT_SMALL;
        shr_large = sum >> SHIFT_LARGE;
    end

    always_comb begin
        unique case (shift)
            SHR_SMALL: value = op_signed ? sar_small : shr_small;
            SHR_LARGE: value = op_signed ? sar_large : shr_large;
            default:   value = sum;
        endcase
    end

endmodule

// File: rtl/vlane_muladd.sv
module vlane_muladd
    import vlane_pkg::*;
#(
    parameter int unsigned SHIFT_SMALL = 7,
    parameter int unsigned SHIFT_LARGE = 15
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [WORD_W-1:0]     a_word,
    input  logic                  a_byte_mode,
    input  logic [BYTE_IDX_W-1:0] a_byte_idx,
    input  logic [1:0]            a_half_sel,
    input  logic                  a_signed,
    input  logic [WORD_W-1:0]     b_word,
    input  logic [IMM_W-1:0]      b_imm,
    input  logic                  b_from_imm,
    input  logic                  b_byte_mode,
    input  logic [BYTE_IDX_W-1:0] b_byte_idx,
    input  logic [1:0]            b_half_sel,
    input  logic                  b_signed,
    input  logic [WORD_W-1:0]     c_word,
    input  logic [1:0]            shift_sel,
    output logic                  out_valid,
    output logic [WORD_W-1:0]     result,
    output logic                  err
);

    lane_ctl_t         a_ctl;
    lane_ctl_t         b_ctl;
    logic [WORD_W-1:0] a_lane;
    logic [WORD_W-1:0] b_lane;
    logic              a_bad;
    logic              b_bad;
    stage_t            st1_d;
    stage_t            st1;
    logic [WORD_W-1:0] mac_value;

    assign a_ctl = '{byte_mode: a_byte_mode, byte_idx: a_byte_idx,
                     half_sel: half_sel_e'(a_half_sel), is_signed: a_signed};
    assign b_ctl = '{byte_mode: b_byte_mode, byte_idx: b_byte_idx,
                     half_sel: half_sel_e'(b_half_sel), is_signed: b_signed};

    vlane_lane_pick #(.HAS_IMM(1'b0)) u_pick_a (
        .word    (a_word),
        .imm     ('0),
        .use_imm (1'b0),
        .ctl     (a_ctl),
        .operand (a_lane),
        .bad     (a_bad)
    );

    vlane_lane_pick #(.HAS_IMM(1'b1)) u_pick_b (
        .word    (b_word),
        .imm     (b_imm),
        .use_imm (b_from_imm),
        .ctl     (b_ctl),
        .operand (b_lane),
        .bad     (b_bad)
    );

    always_comb begin
        st1_d.valid     = in_valid;
        st1_d.err       = a_bad | b_bad;
        st1_d.op_signed = a_signed | b_signed;
        st1_d.shift     = shift_sel_e'(shift_sel);
        st1_d.a_op      = a_lane;
        st1_d.b_op      = b_lane;
        st1_d.c_op      = c_word;
    end

    // Stage 1: extracted operands
    always_ff @(posedge clk) begin
        if (rst) begin
            st1 <= '0;
        end else begin
            if (in_valid) begin
                st1 <= st1_d;
            end
            st1.valid <= in_valid;
        end
    end

    vlane_mac #(
        .SHIFT_SMALL (SHIFT_SMALL),
        .SHIFT_LARGE (SHIFT_LARGE)
    ) u_mac (
        .a_op      (st1.a_op),
        .b_op      (st1.b_op),
        .c_op      (st1.c_op),
        .op_signed (st1.op_signed),
        .shift     (st1.shift),
        .value     (mac_value)
    );

    // Stage 2: result register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            err       <= 1'b0;
        end else begin
            out_valid <= st1.valid;
            if (st1.valid) begin
                result <= st1.err ? '0 : mac_value;
                err    <= st1.err;
            end
        end
    end

endmodule

// File: rtl/vlane_muladd_chk.sv
module vlane_muladd_chk
    import vlane_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              a_byte_mode,
    input logic [1:0]        a_half_sel,
    input logic              b_from_imm,
    input logic              b_byte_mode,
    input logic [1:0]        b_half_sel,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic              err
);

    logic [1:0] since_rst;
    logic       bad_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd2) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    assign bad_in = (!a_byte_mode && a_half_sel >= 2'd2) ||
                    (!b_from_imm && !b_byte_mode && b_half_sel >= 2'd2);

    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    assert_err_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && err) |-> (result == '0));

    assert_err_raised_R7: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2 && out_valid && $past(bad_in, 2)) |-> err);

    assert_err_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2 && out_valid && !$past(bad_in, 2)) |-> !err);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 2'd0 && !out_valid) |-> ($stable(result) && $stable(err)));

endmodule

bind vlane_muladd vlane_muladd_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .a_byte_mode (a_byte_mode),
    .a_half_sel  (a_half_sel),
    .b_from_imm  (b_from_imm),
    .b_byte_mode (b_byte_mode),
    .b_half_sel  (b_half_sel),
    .out_valid   (out_valid),
    .result      (result),
    .err         (err)
);

// File: tb/vlane_muladd_tb.sv
`timescale 1ns/1ps
module vlane_muladd_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] a_word, b_word, c_word;
    logic        a_byte_mode, b_byte_mode, b_from_imm, a_signed, b_signed;
    logic [1:0]  a_byte_idx, b_byte_idx, a_half_sel, b_half_sel, shift_sel;
    logic [15:0] b_imm;
    logic        out_valid, err;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vlane_muladd u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_word(a_word), .a_byte_mode(a_byte_mode), .a_byte_idx(a_byte_idx),
        .a_half_sel(a_half_sel), .a_signed(a_signed),
        .b_word(b_word), .b_imm(b_imm), .b_from_imm(b_from_imm),
        .b_byte_mode(b_byte_mode), .b_byte_idx(b_byte_idx),
        .b_half_sel(b_half_sel), .b_signed(b_signed),
        .c_word(c_word), .shift_sel(shift_sel),
        .out_valid(out_valid), .result(result), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic longint pick(input logic [31:0] w, input logic bm, input logic [1:0] idx,
                                    input logic [1:0] hs, input logic sg, output bit bad);
        longint v;
        bad = 1'b0;
        if (bm) begin
            v = longint'((w >> (8 * int'(idx))) & 32'hFF);
            if (sg && v >= 128) v = v - 256;
        end else if (hs < 2'd2) begin
            v = longint'((w >> (16 * int'(hs))) & 32'hFFFF);
            if (sg && v >= 32768) v = v - 65536;
        end else begin
            v = 0;
            bad = 1'b1;
        end
        return v;
    endfunction

    // Expected value from the bench's own copy of the driven inputs
    task automatic model(output logic [31:0] res, output logic e);
        longint av, bv, tot, ss;
        bit     abad, bbad;
        logic [31:0] s32;
        int     k;
        av = pick(a_word, a_byte_mode, a_byte_idx, a_half_sel, a_signed, abad);
        if (b_from_imm) begin
            bv = longint'(b_imm);
            if (b_signed && bv >= 32768) bv = bv - 65536;
            bbad = 1'b0;
        end else begin
            bv = pick(b_word, b_byte_mode, b_byte_idx, b_half_sel, b_signed, bbad);
        end
        tot = av * bv + longint'(c_word);
        s32 = tot[31:0];
        k = (shift_sel == 2'd1) ? 7 : (shift_sel == 2'd2) ? 15 : 0;
        if (a_signed || b_signed) begin
            ss  = longint'(signed'(s32));
            ss  = ss >>> k;
            res = ss[31:0];
        end else begin
            res = s32 >> k;
        end
        e = abad | bbad;
        if (e) res = 32'h0;
    endtask

    function automatic string tag_of();
        string t;
        if ((!a_byte_mode && a_half_sel >= 2'd2) ||
            (!b_from_imm && !b_byte_mode && b_half_sel >= 2'd2)) t = "R7";
        else if (b_from_imm) t = "R4";
        else if (shift_sel == 2'd1 || shift_sel == 2'd2) t = "R6";
        else if (a_byte_mode) t = "R1";
        else t = "R2";
        if (a_signed || b_signed) t = {t, " R3"};
        return {t, " R5"};
    endfunction

    task automatic set_cfg(input int ac, input int bc, input int sg, input int sh);
        a_byte_mode = (ac < 4);
        a_byte_idx  = 2'(ac % 4);
        a_half_sel  = 2'(ac % 4);
        b_from_imm  = (bc == 8);
        b_byte_mode = (bc < 4);
        b_byte_idx  = 2'(bc % 4);
        b_half_sel  = (bc == 8) ? 2'd3 : 2'(bc % 4);
        a_signed    = sg[0];
        b_signed    = sg[1];
        shift_sel   = 2'(sh);
    endtask

    // One isolated transfer; starts and ends just after a falling edge
    task automatic run_one(input bit hold_test);
        logic [31:0] er;
        logic        ee;
        string       t;
        model(er, ee);
        t = tag_of();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check({t, " result"}, result, er);
        check({"R7 err ", t}, {31'd0, err}, {31'd0, ee});
        check("R8 out_valid", {31'd0, out_valid}, 32'd1);
        if (hold_test) begin
            for (int i = 0; i < 3; i++) begin
                a_word = $urandom; b_word = $urandom; c_word = $urandom;
                a_half_sel = 2'd3; shift_sel = 2'(i);
                @(negedge clk);
            end
            check("R9 hold result", result, er);
            check("R9 hold err", {31'd0, err}, {31'd0, ee});
            check("R9 out_valid low", {31'd0, out_valid}, 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] exp_q [16];
        logic        err_q [16];
        rst = 1'b1; in_valid = 1'b0;
        a_word = '0; b_word = '0; c_word = '0; b_imm = '0;
        set_cfg(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R9 reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R9 reset result", result, 32'd0);
        check("R9 reset err", {31'd0, err}, 32'd0);

        // Directed: signed -1 byte times imm 1, shifted by 7 stays -1 (R6)
        a_word = 32'h0000_00FF; c_word = 32'd0; b_imm = 16'h0001; b_word = $urandom;
        set_cfg(0, 8, 3, 1);
        run_one(1'b0);
        check("R6 directed signed shift", result, 32'hFFFF_FFFF);
        set_cfg(0, 8, 0, 1);
        run_one(1'b0);
        check("R6 directed unsigned shift", result, 32'h0000_0001);

        // Sweep of lane configurations, signs and shift codes
        for (int p = 0; p < 2; p++) begin
            for (int ac = 0; ac < 8; ac++) begin
                for (int bc = 0; bc < 9; bc++) begin
                    for (int sg = 0; sg < 4; sg++) begin
                        for (int sh = 0; sh < 4; sh++) begin
                            if (p == 0) begin
                                a_word = 32'hFF80_7F81; b_word = 32'h8001_FFFE;
                                c_word = 32'h7FFF_FFF0; b_imm  = 16'h8003;
                            end else begin
                                a_word = $urandom; b_word = $urandom;
                                c_word = $urandom; b_imm  = 16'($urandom);
                            end
                            set_cfg(ac, bc, sg, sh);
                            run_one((ac == 5 && sh == 1 && sg == 2));
                        end
                    end
                end
            end
        end

        // Back-to-back stream, one transfer per cycle (R8)
        for (int i = 0; i < 18; i++) begin
            if (i >= 2) begin
                check($sformatf("R8 stream result %0d", i - 2), result, exp_q[i-2]);
                check("R8 stream valid", {31'd0, out_valid}, 32'd1);
                check("R8 stream err", {31'd0, err}, {31'd0, err_q[i-2]});
            end
            if (i < 16) begin
                a_word = $urandom; b_word = $urandom; c_word = $urandom;
                b_imm = 16'($urandom);
                set_cfg(i % 8, i % 9, i % 4, (i / 4) % 4);
                model(exp_q[i], err_q[i]);
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
        check("R8 stream drained", {31'd0, out_valid}, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule